// File: doc/BRIEF.md
# Dual-Channel Serial ADC Reader

This block runs an external two-channel, 16-bit serial converter. It starts a conversion by driving a conversion-start line low, waits for the converter to raise its busy line, and then reads two serial words in a row from a single data input. The first word is channel A and the second is channel B. The block's system clock also serves as the serial bit clock, and it runs without stopping. It has to run at 32 MHz or more so that both words are read while the next conversion is still in progress. After the second word arrives, both words are copied into output registers on the same edge and a one-cycle valid strobe marks the new pair. The block then starts the next conversion by itself.

The controller is a five-state machine that always runs in the same order. ST_IDLE holds the start line high for one cycle and always moves on to ST_START. ST_START drives the start line low and stays there until busy is seen high, then moves to ST_RD_A. ST_RD_A shifts in 16 bits and moves on to ST_RD_B. ST_RD_B shifts in 16 bits and moves on to ST_CAPTURE. ST_CAPTURE copies both words out and returns to ST_IDLE. One bit counter is shared by the two read states. It is cleared whenever the machine is not reading and again at the last bit of each word.

Top module: `dual_adc_reader`

## Requirements
- R1: A synchronous active-high reset puts the machine in ST_IDLE. While reset is applied, the conversion-start output is high, both sample outputs are zero and the valid strobe is low.
- R2: The conversion-start output is high for exactly one cycle (ST_IDLE). It is low from the next cycle on (ST_START).
- R3: In ST_START the busy input is sampled on every rising edge. While it is low the machine stays in ST_START and the start line stays low. The first edge that sees it high moves the machine to ST_RD_A.
- R4: The 16 rising edges that follow the edge on which busy was seen high each sample one data bit into channel A, most significant bit first.
- R5: The 16 rising edges after that each sample one bit into channel B, most significant bit first, with no gap between the two words.
- R6: On the edge after the last channel-B bit, both sample outputs take their new words on the same edge. The valid strobe is high for exactly that one cycle.
- R7: At all other times the sample outputs keep their values and the valid strobe is low.
- R8: The busy input has no effect outside ST_START. The data input has no effect outside the two read states.
- R9: The cycle repeats without outside help. The conversion-start line is high in the same cycle as the valid strobe, and low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the continuous serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| adc_busy | input | 1 | Busy indication from the converter |
| adc_sdata | input | 1 | Serial result data from the converter |
| adc_conv_start | output | 1 | Conversion start; a falling edge begins a conversion |
| sample_a | output | 16 | Last captured channel-A word |
| sample_b | output | 16 | Last captured channel-B word |
| sample_valid | output | 1 | One-cycle strobe marking a new A/B pair |

## Verification
The checker does not model the busy pulse. It only assumes that busy eventually rises while the machine waits in ST_START, and that reset is held for more than one cycle so that the output-stability property starts from defined values. The bench drives every input on the falling edge of the clock. It holds reset for several cycles each time it applies it, and it raises busy only after it has seen the start line go low. Busy is sometimes held high and sometimes toggled during the reads, and random data is placed on the data line while the machine is waiting. This shows that those inputs outside their windows do not change the captured pair.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    // Controller states, visited in this fixed order.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_START   = 3'd1,
        ST_RD_A    = 3'd2,
        ST_RD_B    = 3'd3,
        ST_CAPTURE = 3'd4
    } rd_state_e;

endpackage

// File: rtl/bit_tally.sv
// Counts serial bits within one word and flags the final bit.
module bit_tally #(
    parameter int WORD_W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = step && (cnt == LAST_IDX);

endmodule

// File: rtl/serial_word_shifter.sv
// MSB-first serial-to-parallel shifter for one channel.
module serial_word_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              din,
    output logic [WORD_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[WORD_W-2:0], din};
        end
    end

endmodule

// File: rtl/dual_adc_reader.sv
module dual_adc_reader
    import adc_rd_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adc_busy,
    input  logic              adc_sdata,
    output logic              adc_conv_start,
    output logic [WORD_W-1:0] sample_a,
    output logic [WORD_W-1:0] sample_b,
    output logic              sample_valid
);
    localparam int NUM_CH = 2;

    rd_state_e state;
    rd_state_e state_nx;

    logic              bit_last;
    logic              tally_step;
    logic              tally_clear;
    logic [NUM_CH-1:0] ch_shift;
    logic [WORD_W-1:0] ch_word [NUM_CH];

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transition logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    state_nx = ST_START;
            ST_START:   if (adc_busy) state_nx = ST_RD_A;
            ST_RD_A:    if (bit_last) state_nx = ST_RD_B;
            ST_RD_B:    if (bit_last) state_nx = ST_CAPTURE;
            ST_CAPTURE: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Channel select: channel 0 reads first, channel 1 second.
    assign ch_shift[0] = (state == ST_RD_A);
    assign ch_shift[1] = (state == ST_RD_B);
    assign tally_step  = |ch_shift;
    assign tally_clear = !tally_step || bit_last;

    bit_tally #(.WORD_W(WORD_W)) u_tally (
        .clk   (clk),
        .rst   (rst),
        .clear (tally_clear),
        .step  (tally_step),
        .last  (bit_last)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        serial_word_shifter #(.WORD_W(WORD_W)) u_shf (
            .clk      (clk),
            .rst      (rst),
            .shift_en (ch_shift[ch]),
            .din      (adc_sdata),
            .word     (ch_word[ch])
        );
    end

    // Output process
    always_comb begin
        adc_conv_start = (state == ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_a     <= '0;
            sample_b     <= '0;
            sample_valid <= 1'b0;
        end else begin
            sample_valid <= (state == ST_CAPTURE);
            if (state == ST_CAPTURE) begin
                sample_a <= ch_word[0];
                sample_b <= ch_word[1];
            end
        end
    end

endmodule

// File: rtl/adc_reader_chk.sv
module adc_reader_chk
    import adc_rd_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              adc_busy,
    input logic              adc_conv_start,
    input logic [WORD_W-1:0] sample_a,
    input logic [WORD_W-1:0] sample_b,
    input logic              sample_valid,
    input rd_state_e         st
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_RUN = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] FULL_RUN = CNT_W'(WORD_W);

    logic             rst_q;
    logic [CNT_W-1:0] a_run;
    logic [CNT_W-1:0] b_run;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        a_run <= (!rst && st == ST_RD_A) ? a_run + 1'b1 : '0;
        b_run <= (!rst && st == ST_RD_B) ? b_run + 1'b1 : '0;
    end

    // R1
    always @(posedge clk) begin
        if (rst_q === 1'b1) begin
            reset_state_chk: assert (adc_conv_start && !sample_valid &&
                                     sample_a == '0 && sample_b == '0)
                else $error("reset state wrong");
        end
    end

    // R2
    idle_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        adc_conv_start |=> !adc_conv_start);

    // R3
    busy_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_START && !adc_busy) |=> (st == ST_START && !adc_conv_start));

    // R3
    busy_go_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_START && adc_busy) |=> (st == ST_RD_A));

    // R4
    a_len_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RD_A) |-> (a_run < FULL_RUN));

    // R4
    a_done_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RD_A && a_run == LAST_RUN) |=> (st == ST_RD_B));

    // R5
    b_len_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RD_B) |-> (b_run < FULL_RUN));

    // R5
    b_done_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RD_B && b_run == LAST_RUN) |=> (st == ST_CAPTURE));

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sample_valid && !$past(rst)) |-> ($stable(sample_a) && $stable(sample_b)));

    // R9
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> adc_conv_start);

endmodule

bind dual_adc_reader adc_reader_chk #(.WORD_W(WORD_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .adc_busy       (adc_busy),
    .adc_conv_start (adc_conv_start),
    .sample_a       (sample_a),
    .sample_b       (sample_b),
    .sample_valid   (sample_valid),
    .st             (state)
);

// File: tb/sim_dual_adc_reader.sv
`timescale 1ns/1ps
module sim_dual_adc_reader;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         adc_busy = 1'b0;
    logic         adc_sdata = 1'b0;
    logic         adc_conv_start;
    logic [W-1:0] sample_a;
    logic [W-1:0] sample_b;
    logic         sample_valid;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dual_adc_reader #(.WORD_W(W)) u0 (
        .clk            (clk),
        .rst            (rst),
        .adc_busy       (adc_busy),
        .adc_sdata      (adc_sdata),
        .adc_conv_start (adc_conv_start),
        .sample_a       (sample_a),
        .sample_b       (sample_b),
        .sample_valid   (sample_valid)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R1: apply reset for several cycles and check the reset state
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        adc_busy = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 conv_start", 32'(adc_conv_start), 32'd1);
        chk("R1 valid", 32'(sample_valid), 32'd0);
        chk("R1 sample_a", 32'(sample_a), 32'd0);
        chk("R1 sample_b", 32'(sample_b), 32'd0);
        rst = 1'b0;
    endtask

    // One full conversion; called at a falling edge.
    task automatic run_conv(logic [W-1:0] a, logic [W-1:0] b, int n_wait,
                            bit busy_high, logic [W-1:0] old_a, logic [W-1:0] old_b);
        while (adc_conv_start) @(negedge clk);
        // R3: hold busy low, toggle data, machine must keep waiting
        for (int i = 0; i < n_wait; i++) begin
            adc_busy  = 1'b0;
            adc_sdata = 1'($urandom);
            @(negedge clk);
            chk("R3 start stays low while waiting", 32'(adc_conv_start), 32'd0);
        end
        adc_busy = 1'b1;
        @(negedge clk);
        // R4: channel A bits, MSB first; R8: busy toggled when not held
        for (int i = W - 1; i >= 0; i--) begin
            adc_sdata = a[i];
            adc_busy  = busy_high ? 1'b1 : 1'(i & 1);
            @(negedge clk);
        end
        // R5: channel B bits directly after
        for (int i = W - 1; i >= 0; i--) begin
            adc_sdata = b[i];
            adc_busy  = busy_high ? 1'b1 : 1'(i & 1);
            @(negedge clk);
        end
        // Capture cycle: outputs still hold the previous pair (R7)
        adc_sdata = ~adc_sdata;
        chk("R7 valid low before capture", 32'(sample_valid), 32'd0);
        chk("R7 sample_a held", 32'(sample_a), 32'(old_a));
        chk("R7 sample_b held", 32'(sample_b), 32'(old_b));
        @(negedge clk);
        chk("R6 valid pulse", 32'(sample_valid), 32'd1);
        chk("R4 R8 sample_a", 32'(sample_a), 32'(a));
        chk("R5 R8 sample_b", 32'(sample_b), 32'(b));
        chk("R9 start high with valid", 32'(adc_conv_start), 32'd1);
        adc_busy = 1'b1;
        @(negedge clk);
        chk("R6 valid one cycle", 32'(sample_valid), 32'd0);
        chk("R2 start low after one cycle", 32'(adc_conv_start), 32'd0);
        chk("R7 sample_a kept", 32'(sample_a), 32'(a));
        chk("R7 sample_b kept", 32'(sample_b), 32'(b));
        adc_busy = 1'b0;
    endtask

    // R1: reset applied in the middle of channel A
    task automatic reset_mid_read();
        while (adc_conv_start) @(negedge clk);
        adc_busy = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            adc_sdata = 1'b1;
            @(negedge clk);
        end
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 mid-read conv_start", 32'(adc_conv_start), 32'd1);
        chk("R1 mid-read valid", 32'(sample_valid), 32'd0);
        chk("R1 mid-read sample_a", 32'(sample_a), 32'd0);
        chk("R1 mid-read sample_b", 32'(sample_b), 32'd0);
        rst = 1'b0;
        adc_busy = 1'b0;
        @(negedge clk);
        chk("R2 idle after reset", 32'(adc_conv_start), 32'd0);
    endtask

    initial begin
        do_reset();
        chk("R2 idle one cycle after reset", 32'(adc_conv_start), 32'd1);
        run_conv(16'hA5C3, 16'h1234, 0, 1'b1, 16'h0000, 16'h0000);
        run_conv(16'h8001, 16'hFFFE, 5, 1'b0, 16'hA5C3, 16'h1234);
        run_conv(16'h0000, 16'hFFFF, 2, 1'b1, 16'h8001, 16'hFFFE);
        run_conv(16'h7FFF, 16'h0001, 1, 1'b0, 16'h0000, 16'hFFFF);
        reset_mid_read();
        run_conv(16'h5A5A, 16'hC0DE, 3, 1'b0, 16'h0000, 16'h0000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule